// File: doc/BRIEF.md
# Unsigned Add/Subtract Unit with Chained Condition Code

This block is the unsigned arithmetic slice of a CPU execute stage. It adds or subtracts two operands, either plain or chained through a carry or borrow held in its own 2-bit condition-code register. It works at a narrow (32-bit) or a wide (64-bit) width. Multiword arithmetic is built by issuing a plain add or subtract for the lowest word, then chained operations for the higher words. Each chained step takes its carry or borrow from the condition code that the step before it left.

The issuing logic presents an operation code, a width bit, two operands, the old 64-bit destination value and a valid strobe. One clock later the unit returns the new destination value and a done strobe, and shows the updated condition code. In narrow mode only the low half of the destination is replaced. The condition code holds two flags. Bit 0 means the width-truncated result is nonzero. Bit 1 means carry out for additions and no borrow for subtractions.

Top module: `lac_unit`

## Requirements
- R1: After a synchronous reset the condition code reads 0 and done is low.
- R2: Operation code 00 (add) returns a + b truncated to the selected width. Width bit 0 selects 32 bits and 1 selects 64 bits.
- R3: For operation 00, condition-code bit 1 is set exactly when the true sum does not fit the width, which is when the truncated result is below a.
- R4: Operation code 01 (add with carry) returns a + b + c, where c is condition-code bit 1 as it stood when the operation was issued.
- R5: For operation 01, bit 1 reports the carry out of the full three-term sum. So with c = 1 and b all ones at the width, the carry is set, even when a + b alone would not carry.
- R6: Operation code 10 (subtract) returns a - b. Bit 1 is 1 when b <= a (no borrow) and 0 when b > a.
- R7: Operation code 11 (subtract with borrow) returns a - b - (1 - c), with c being condition-code bit 1. Bit 1 is 0 (borrow) exactly when b + (1 - c) > a. This includes the case where a borrow is pending and b is all ones at the width, which always borrows.
- R8: In 32-bit mode, result bits 63:32 equal the destination input's bits 63:32. Operand bits 63:32 have no effect on the result or the condition code.
- R9: The result, done and the new condition code appear on the cycle after valid. The condition code holds its value in cycles without valid.
- R10: Condition-code bit 0 is 1 exactly when the result bits of the selected width are not all zero. A chained operation that wraps to exactly zero gives code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation is presented this cycle |
| op_i | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| wide_i | input | 1 | 0 = 32-bit, 1 = 64-bit |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (subtrahend for subtraction) |
| dest_i | input | 64 | Old destination value |
| res_o | output | 64 | New destination value |
| cc_o | output | 2 | Condition code: bit 1 carry/no-borrow, bit 0 nonzero |
| done_o | output | 1 | Result valid (one cycle after valid_i) |

## Verification
The hardest situation to reach is a chained operation whose carry or borrow input is the opposite of its plain default, with b all ones at the width. Only this case separates a correct carry from one taken from a + b alone. The ports cannot set the flag directly, so the stimulus first issues an overflowing add or a borrowing subtract to leave the needed flag. It then issues the chained operation with b all ones, and with a chosen so that the result wraps to exactly zero or stays nonzero. The same preparation is repeated in narrow mode with nonzero upper operand bits. A long random stream of back-to-back operations then chains flags from one operation to the next.

// File: rtl/lac_pkg.sv
package lac_pkg;

    localparam int unsigned XLEN_DEF = 64;
    localparam int unsigned HLEN_DEF = 32;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_ADDC = 2'b01,
        ALU_SUB  = 2'b10,
        ALU_SUBB = 2'b11
    } alu_op_e;

    // Packs so that carry is bit 1 and nonzero is bit 0.
    typedef struct packed {
        logic carry;
        logic nonzero;
    } ccode_t;

    function automatic logic op_is_sub(alu_op_e op);
        return op[1];
    endfunction

    // Carry into the adder.
    // Plain ops use the fixed default: 0 for add, 1 for the two's complement of subtract.
    // Chained ops take condition-code bit 1.
    function automatic logic op_carry_in(alu_op_e op, ccode_t cc);
        logic c;
        case (op)
            ALU_ADD:  c = 1'b0;
            ALU_SUB:  c = 1'b1;
            default:  c = cc.carry;
        endcase
        return c;
    endfunction

    function automatic ccode_t make_cc(logic carry, logic nonzero);
        ccode_t r;
        r.carry   = carry;
        r.nonzero = nonzero;
        return r;
    endfunction

endpackage

// File: rtl/lac_lane.sv
module lac_lane #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   total;

    // The carry out of the (W+1)-bit sum already includes the carry in,
    // so the all-ones second operand case needs no special path.
    assign b_eff = sub ? ~b : b;
    assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    assign sum   = total[W-1:0];
    assign cout  = total[W];
endmodule

// File: rtl/lac_merge.sv
module lac_merge
    import lac_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] dest,
    input  logic [DATA_W-1:0] sum_n,
    input  logic              cout_n,
    input  logic [DATA_W-1:0] sum_w,
    input  logic              cout_w,
    output logic [DATA_W-1:0] res,
    output ccode_t            cc
);
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [DATA_W-1:0] narrow_res;

    assign narrow_res = (dest & ~LOW_MASK) | (sum_n & LOW_MASK);

    always_comb begin
        if (wide) begin
            res = sum_w;
            cc  = make_cc(cout_w, |sum_w);
        end else begin
            res = narrow_res;
            cc  = make_cc(cout_n, |(sum_n & LOW_MASK));
        end
    end
endmodule

// File: rtl/lac_unit.sv
module lac_unit
    import lac_pkg::*;
#(
    parameter int unsigned DATA_W   = XLEN_DEF,
    parameter int unsigned NARROW_W = HLEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [1:0]        op_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] dest_i,
    output logic [DATA_W-1:0] res_o,
    output logic [1:0]        cc_o,
    output logic              done_o
);
    localparam int unsigned NLANE = 2;

    alu_op_e           op;
    ccode_t            cc_q;
    ccode_t            cc_next;
    logic              cin;
    logic              sub;
    logic [DATA_W-1:0] lane_sum  [NLANE];
    logic              lane_cout [NLANE];
    logic [DATA_W-1:0] res_next;
    logic [DATA_W-1:0] res_q;
    logic              done_q;

    assign op  = alu_op_e'(op_i);
    assign sub = op_is_sub(op);
    assign cin = op_carry_in(op, cc_q);

    // Lane 0 is the narrow width and lane 1 the wide width.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int unsigned LW = (g == 0) ? NARROW_W : DATA_W;
        logic [LW-1:0] s;
        logic          co;

        lac_lane #(.W(LW)) u_lane (
            .a    (a_i[LW-1:0]),
            .b    (b_i[LW-1:0]),
            .sub  (sub),
            .cin  (cin),
            .sum  (s),
            .cout (co)
        );

        always_comb begin
            lane_sum[g]        = '0;
            lane_sum[g][LW-1:0] = s;
            lane_cout[g]       = co;
        end
    end

    lac_merge #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_merge (
        .wide   (wide_i),
        .dest   (dest_i),
        .sum_n  (lane_sum[0]),
        .cout_n (lane_cout[0]),
        .sum_w  (lane_sum[1]),
        .cout_w (lane_cout[1]),
        .res    (res_next),
        .cc     (cc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q   <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= valid_i;
            if (valid_i) begin
                cc_q  <= cc_next;
                res_q <= res_next;
            end
        end
    end

    assign res_o  = res_q;
    assign cc_o   = cc_q;
    assign done_o = done_q;

    // R9: done follows valid by exactly one cycle
    p_done_lat_r9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);
    p_no_done_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o);
    // R9: condition code holds without valid
    p_cc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(cc_o));
    // R8: narrow mode keeps the upper destination half
    p_upper_keep_r8: assert property (@(posedge clk) disable iff (rst)
        valid_i && !wide_i |=> res_o[DATA_W-1:NARROW_W] == $past(dest_i[DATA_W-1:NARROW_W]));
    // R3: plain wide add carries exactly when the result is below a
    p_add_carry_r3: assert property (@(posedge clk) disable iff (rst)
        valid_i && wide_i && op_i == 2'b00 |=> cc_o[1] == (res_o < $past(a_i)));
    // R7: pending borrow with all-ones subtrahend always borrows
    p_ones_borrow_r7: assert property (@(posedge clk) disable iff (rst)
        valid_i && wide_i && op_i == 2'b11 && !cc_o[1] && (&b_i) |=> !cc_o[1]);
    // R10: nonzero flag matches the result at the selected width
    p_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> cc_o[0] == ($past(wide_i) ? (|res_o) : (|res_o[NARROW_W-1:0])));
endmodule

// File: tb/sim_lac_unit.sv
module sim_lac_unit;
    import lac_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [1:0]  op_i;
    logic        wide_i;
    logic [63:0] a_i, b_i, dest_i;
    logic [63:0] res_o;
    logic [1:0]  cc_o;
    logic        done_o;

    always #10 clk = ~clk;

    lac_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .wide_i(wide_i),
        .a_i(a_i), .b_i(b_i), .dest_i(dest_i),
        .res_o(res_o), .cc_o(cc_o), .done_o(done_o)
    );

    typedef struct {
        logic [63:0] res;
        logic [1:0]  cc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    logic [1:0] cc_model = 2'b00;
    bit   finished = 0;

    localparam logic [63:0] ONES = {64{1'b1}};

    // Reference model: wider arithmetic, borrow by comparison
    function automatic void model(input logic [1:0] op, input logic wide,
                                  input logic [63:0] a, input logic [63:0] b,
                                  input logic [63:0] dest, input logic [1:0] ccin,
                                  output logic [63:0] res, output logic [1:0] cc);
        logic [65:0] mask, am, bm, t, bin;
        logic c;
        mask = wide ? {2'b00, ONES} : {34'd0, 32'hFFFF_FFFF};
        am = {2'b00, a} & mask;
        bm = {2'b00, b} & mask;
        case (op)
            2'b00: begin t = am + bm; c = (t > mask); end
            2'b01: begin t = am + bm + {65'd0, ccin[1]}; c = (t > mask); end
            2'b10: begin c = !(bm > am); t = am - bm; end
            default: begin
                bin = {65'd0, !ccin[1]};
                c = !((bm + bin) > am);
                t = am - bm - bin;
            end
        endcase
        t = t & mask;
        res = wide ? t[63:0] : {dest[63:32], t[31:0]};
        cc = {c, (t != 66'd0)};
    endfunction

    task automatic issue(input logic [1:0] op, input logic wide, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] dest, input string tag);
        exp_t e;
        logic [63:0] r;
        logic [1:0] c;
        @(negedge clk);
        model(op, wide, a, b, dest, cc_model, r, c);
        cc_model = c;
        e.res = r; e.cc = c; e.tag = tag;
        q.push_back(e);
        valid_i = 1'b1; op_i = op; wide_i = wide; a_i = a; b_i = b; dest_i = dest;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            a_i = $urandom; b_i = $urandom; op_i = 2'($urandom);
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R9 unexpected done", {63'd0, done_o}, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(res_o == e.res, {e.tag, " result"}, res_o, e.res);
                check(cc_o == e.cc, {e.tag, " cc"}, {62'd0, cc_o}, {62'd0, e.cc});
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; op_i = 2'b00; wide_i = 1'b0;
        a_i = '0; b_i = '0; dest_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cc_o == 2'b00, "R1 cc after reset", {62'd0, cc_o}, 64'd0);
        check(done_o == 1'b0, "R1 done after reset", {63'd0, done_o}, 64'd0);
        rst = 1'b0;

        // R2 R3 R10 plain add, wide
        issue(2'b00, 1'b1, 64'd0, 64'd0, 64'd0, "R10 add zero");
        issue(2'b00, 1'b1, 64'd7, 64'd9, 64'd0, "R2 add small");
        issue(2'b00, 1'b1, ONES, 64'd1, 64'd0, "R3 add wrap zero");
        issue(2'b00, 1'b1, ONES, 64'd5, 64'd0, "R3 add carry nonzero");
        // R4 R5: carry in set, b all ones
        issue(2'b00, 1'b1, ONES, 64'd1, 64'd0, "R3 prep carry");
        issue(2'b01, 1'b1, 64'd5, ONES, 64'd0, "R5 addc ones cin1");
        issue(2'b01, 1'b1, 64'd0, ONES, 64'd0, "R5 addc wrap zero");
        issue(2'b01, 1'b1, 64'd10, 64'd20, 64'd0, "R4 addc carry in");
        issue(2'b01, 1'b1, 64'd10, 64'd20, 64'd0, "R4 addc no carry in");
        // R6 subtract
        issue(2'b10, 1'b1, 64'd5, 64'd5, 64'd0, "R6 sub equal");
        issue(2'b10, 1'b1, 64'd3, 64'd5, 64'd0, "R6 sub borrow");
        issue(2'b10, 1'b1, 64'd0, ONES, 64'd0, "R6 sub a0 ones");
        // R7 subtract with borrow, pending borrow, b all ones
        issue(2'b10, 1'b1, 64'd3, 64'd5, 64'd0, "R6 prep borrow");
        issue(2'b11, 1'b1, 64'd7, ONES, 64'd0, "R7 subb ones pending");
        issue(2'b11, 1'b1, ONES, ONES, 64'd0, "R7 subb ones ones pending");
        issue(2'b10, 1'b1, 64'd9, 64'd1, 64'd0, "R6 prep no borrow");
        issue(2'b11, 1'b1, 64'd4, 64'd4, 64'd0, "R7 subb wrap zero");
        issue(2'b11, 1'b1, 64'd0, ONES, 64'd0, "R7 subb a0 ones");
        // R8 narrow mode with dirty upper operand halves
        issue(2'b00, 1'b0, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0001,
              64'hDEAD_BEEF_5555_5555, "R8 add32 wrap");
        issue(2'b01, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_FFFF_FFFF,
              64'h0123_4567_89AB_CDEF, "R8 addc32 ones cin1");
        issue(2'b10, 1'b0, 64'h0000_0001_0000_0002, 64'h0000_0000_0000_0003,
              64'hCAFE_F00D_0000_0000, "R8 sub32 borrow");
        issue(2'b11, 1'b0, 64'h7777_7777_0000_0010, 64'h8888_8888_FFFF_FFFF,
              64'h1111_2222_3333_4444, "R8 subb32 ones pending");
        // R9 idle: cc holds, no done
        idle(6);
        check(cc_o == cc_model, "R9 cc hold idle", {62'd0, cc_o}, {62'd0, cc_model});
        check(done_o == 1'b0, "R9 done low idle", {63'd0, done_o}, 64'd0);
        issue(2'b01, 1'b1, ONES, 64'd0, 64'd0, "R9 addc after idle");
        idle(2);

        // Random back-to-back chaining
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a, b;
            int sel;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            sel = $urandom_range(0, 5);
            if (sel == 0) b = ONES;
            if (sel == 1) a = '0;
            if (sel == 2) b = a;
            issue(2'($urandom), 1'($urandom), a, b, {$urandom, $urandom}, "R2 R4 R6 R7 random");
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        idle(4);
        check(q.size() == 0, "R9 all results returned", 64'(q.size()), 64'd0);
        finish_run();
    end
endmodule